// File: doc/BRIEF.md
# Read-Transaction Handshake Sequencer

This block is the control unit between a bus master and a device-side data transceiver for read transfers. The bus raises a read strobe. The sequencer then selects the device and waits for the device acknowledge. Next it opens the transceiver and acknowledges the bus. When the strobe is withdrawn, it unwinds each handshake in turn. Both inputs cross into the clock domain through a parameterised flop chain. All state is held in flops and updated on the rising clock edge.

The block holds three output flops and one hidden phase flop. The phase flop separates two points of the cycle that show the same port values but need different next moves. The first point is before the transceiver opens. The second is after the strobe has dropped and the device acknowledge is still high. Each flop moves toward its own target equation:
- phase target: `strobe & (phase | ~ack)`
- transceiver-enable target: `ack & phase`
- bus-acknowledge target: the transceiver enable
- device-select target: `enable | phase`

Only one flop may change on any clock edge. When several are ready, a fixed priority picks the one that changes. The block also watches the inputs for changes the handshake does not allow, and raises a sticky error flag when one occurs.

Top module: `rd_hs_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with both inputs low, dev_req_o, xcvr_en_o, bus_ack_o and proto_err_o are all 0.
- R2: bus_ack_o equals the value xcvr_en_o had one clock earlier.
- R3: xcvr_en_o rises only while the synchronized dev_ack_i is high and the phase flop is set. It rises SYNC_STAGES+1 rising edges after dev_ack_i rises.
- R4: From idle, dev_req_o rises SYNC_STAGES+2 edges after rd_strobe_i rises. dev_req_o falls only when xcvr_en_o and bus_ack_o are both already low, one edge after bus_ack_o falls.
- R5: A legal read proceeds in this order:
  - strobe up, then dev_req_o up, then dev_ack_i up;
  - then xcvr_en_o up, then bus_ack_o up, then strobe down;
  - then xcvr_en_o down, then bus_ack_o down, then dev_req_o down, then dev_ack_i down.
  
  No output moves ahead of the input it waits for.
- R6: On any clock edge at most one of dev_req_o, xcvr_en_o and bus_ack_o changes.
- R7: xcvr_en_o falls SYNC_STAGES+2 edges after rd_strobe_i falls, even while dev_ack_i is still high. dev_req_o then falls without waiting for dev_ack_i.
- R8: If rd_strobe_i rises while dev_ack_i is still high from the previous read, dev_req_o stays low. It rises SYNC_STAGES+2 edges after dev_ack_i falls.
- R9: proto_err_o sets SYNC_STAGES+1 edges after any one of these events:
  - rd_strobe_i falls while bus_ack_o is low;
  - rd_strobe_i rises while bus_ack_o is high;
  - dev_ack_i rises while dev_req_o is low;
  - dev_ack_i falls while dev_req_o is high.
- R10: proto_err_o stays set until reset. Legal reads never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_strobe_i | input | 1 | Read strobe from the bus master (asynchronous) |
| dev_ack_i | input | 1 | Acknowledge from the device (asynchronous) |
| dev_req_o | output | 1 | Device select request |
| xcvr_en_o | output | 1 | Data transceiver enable |
| bus_ack_o | output | 1 | Acknowledge returned to the bus master |
| proto_err_o | output | 1 | Sticky flag for an input change out of order |

## Verification
The bench builds the block with SYNC_STAGES set to 3, not the default of 2. Every latency it measures is derived from that value. A latency, or an error-flag delay, that is tied to a two-flop chain instead of to the parameter therefore shows up as a wrong edge count. The deeper chain also widens the window in which one input is still in flight while the outputs react to the other. This brings within reach the early-strobe case with the device acknowledge still high, and the collapse from two to one output change per edge.

// File: rtl/rd_hs_pkg.sv
package rd_hs_pkg;

  typedef struct packed {
    logic phase;
    logic dev_req;
    logic xcvr_en;
    logic bus_ack;
  } hs_state_t;

  // flop chosen to move on this edge, highest priority first
  typedef enum logic [2:0] {
    FIRE_NONE,
    FIRE_ACK,
    FIRE_EN,
    FIRE_PHASE,
    FIRE_REQ
  } fire_e;

endpackage

// File: rtl/rd_hs_sync.sv
module rd_hs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int Last = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[i] <= '0;
      else         chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[Last];
endmodule

// File: rtl/rd_hs_seq.sv
module rd_hs_seq
  import rd_hs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      strobe_i,
  input  logic      ack_i,
  output hs_state_t st_o
);
  hs_state_t st_q, st_d;
  fire_e     fire;
  logic      phase_tgt, en_tgt, bus_ack_tgt, req_tgt;

  always_comb begin
    phase_tgt   = strobe_i & (st_q.phase | ~ack_i);
    en_tgt      = ack_i & st_q.phase;
    bus_ack_tgt = st_q.xcvr_en;
    req_tgt     = st_q.xcvr_en | st_q.phase;
  end

  // one excited flop per edge; bus ack first keeps it exactly one edge behind enable
  always_comb begin
    if      (bus_ack_tgt != st_q.bus_ack) fire = FIRE_ACK;
    else if (en_tgt      != st_q.xcvr_en) fire = FIRE_EN;
    else if (phase_tgt   != st_q.phase)   fire = FIRE_PHASE;
    else if (req_tgt     != st_q.dev_req) fire = FIRE_REQ;
    else                                  fire = FIRE_NONE;
  end

  always_comb begin
    st_d = st_q;
    case (fire)
      FIRE_ACK:   st_d.bus_ack = bus_ack_tgt;
      FIRE_EN:    st_d.xcvr_en = en_tgt;
      FIRE_PHASE: st_d.phase   = phase_tgt;
      FIRE_REQ:   st_d.dev_req = req_tgt;
      default:    st_d = st_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  p_one_change_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(st_q ^ $past(st_q)) <= 1);

  p_ack_follows_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.bus_ack == $past(st_q.xcvr_en));

  p_en_rise_cond_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q.xcvr_en) |-> ($past(ack_i) && $past(st_q.phase)));

  p_req_fall_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(st_q.dev_req) |-> (!st_q.xcvr_en && !st_q.bus_ack));

  p_phase_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(st_q.phase) |-> !$past(strobe_i));
endmodule

// File: rtl/rd_hs_mon.sv
module rd_hs_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic ack_i,
  input  logic dev_req_i,
  input  logic bus_ack_i,
  output logic err_o
);
  logic strobe_q, ack_q, err_q;
  logic strobe_rise, strobe_fall, ack_rise, ack_fall, bad;

  always_comb begin
    strobe_rise = strobe_i & ~strobe_q;
    strobe_fall = ~strobe_i & strobe_q;
    ack_rise    = ack_i & ~ack_q;
    ack_fall    = ~ack_i & ack_q;
    bad = (strobe_fall & ~bus_ack_i) | (strobe_rise & bus_ack_i)
        | (ack_rise & ~dev_req_i)    | (ack_fall & dev_req_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      ack_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      ack_q    <= ack_i;
      err_q    <= err_q | bad;
    end
  end

  assign err_o = err_q;

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_q) |-> err_q);

  p_early_strobe_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_fall && !bus_ack_i) |=> err_q);

  p_ack_unrequested_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rise && !dev_req_i) |=> err_q);
endmodule

// File: rtl/rd_hs_ctrl.sv
module rd_hs_ctrl
  import rd_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_strobe_i,
  input  logic dev_ack_i,
  output logic dev_req_o,
  output logic xcvr_en_o,
  output logic bus_ack_o,
  output logic proto_err_o
);
  localparam int NumIn = 2;

  logic [NumIn-1:0] raw_in, sync_in;
  hs_state_t        st;

  assign raw_in = {dev_ack_i, rd_strobe_i};

  rd_hs_sync #(.STAGES(SYNC_STAGES), .WIDTH(NumIn)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (sync_in)
  );

  rd_hs_seq i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (sync_in[0]),
    .ack_i    (sync_in[1]),
    .st_o     (st)
  );

  rd_hs_mon i_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (sync_in[0]),
    .ack_i     (sync_in[1]),
    .dev_req_i (st.dev_req),
    .bus_ack_i (st.bus_ack),
    .err_o     (proto_err_o)
  );

  assign dev_req_o = st.dev_req;
  assign xcvr_en_o = st.xcvr_en;
  assign bus_ack_o = st.bus_ack;
endmodule

// File: tb/test_rd_hs_ctrl.sv
`timescale 1ns/1ps
module test_rd_hs_ctrl;
  localparam int SS = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_strobe = 1'b0;
  logic dev_ack = 1'b0;
  logic dev_req, xcvr_en, bus_ack, proto_err;

  int checks = 0;
  int errors = 0;
  int multi  = 0;
  logic [2:0] prev_o = '0;

  always #2.5 clk = ~clk;

  rd_hs_ctrl #(.SYNC_STAGES(SS)) i_rd_hs_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rd_strobe_i (rd_strobe),
    .dev_ack_i   (dev_ack),
    .dev_req_o   (dev_req),
    .xcvr_en_o   (xcvr_en),
    .bus_ack_o   (bus_ack),
    .proto_err_o (proto_err)
  );

  // R6 monitor: count edges where more than one output moved
  always @(negedge clk) begin
    if (rst_ni && ($countones({dev_req, xcvr_en, bus_ack} ^ prev_o) > 1)) multi++;
    prev_o = {dev_req, xcvr_en, bus_ack};
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic outv(input int w);
    case (w)
      0:       return dev_req;
      1:       return xcvr_en;
      2:       return bus_ack;
      default: return proto_err;
    endcase
  endfunction

  task automatic wait_out(input int w, input logic v, output int n);
    n = 0;
    while (outv(w) !== v && n < 40) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_ni = 1'b0; rd_strobe = 1'b0; dev_ack = 1'b0;
    idle(2);
    chk({dev_req, xcvr_en, bus_ack, proto_err} == 4'b0, "R1 during reset",
        {dev_req, xcvr_en, bus_ack, proto_err}, 0);
    rst_ni = 1'b1;
    idle(3);
    chk({dev_req, xcvr_en, bus_ack, proto_err} == 4'b0, "R1 after release",
        {dev_req, xcvr_en, bus_ack, proto_err}, 0);
  endtask

  task automatic t_read(input int gap, input bit keep_ack);
    int n;
    rd_strobe = 1'b1;
    wait_out(0, 1'b1, n);
    chk(n == SS + 2, "R4 req rise latency", n, SS + 2);
    idle(gap);
    chk(dev_req && !xcvr_en && !bus_ack, "R5 waits for device ack",
        {dev_req, xcvr_en, bus_ack}, 3'b100);
    dev_ack = 1'b1;
    wait_out(1, 1'b1, n);
    chk(n == SS + 1, "R3 enable rise latency", n, SS + 1);
    chk(!bus_ack, "R2 ack still low with enable", bus_ack, 0);
    idle(1);
    chk(bus_ack, "R2 ack one edge after enable", bus_ack, 1);
    idle(gap);
    chk(dev_req && xcvr_en && bus_ack, "R5 holds while strobe high",
        {dev_req, xcvr_en, bus_ack}, 3'b111);
    rd_strobe = 1'b0;
    wait_out(1, 1'b0, n);
    chk(n == SS + 2, "R7 enable fall latency", n, SS + 2);
    chk(dev_req && bus_ack, "R5 enable falls first", {dev_req, bus_ack}, 2'b11);
    wait_out(2, 1'b0, n);
    chk(n == 1, "R2 ack fall one edge after enable", n, 1);
    chk(dev_req, "R4 req still high when ack falls", dev_req, 1);
    wait_out(0, 1'b0, n);
    chk(n == 1, "R7 req falls without device ack drop", n, 1);
    if (!keep_ack) begin
      idle(gap);
      dev_ack = 1'b0;
      idle(SS + 3);
      chk(!proto_err, "R10 legal read leaves error low", proto_err, 0);
    end
  endtask

  task automatic t_early_strobe;
    int n;
    t_read(2, 1'b1);
    rd_strobe = 1'b1;
    idle(SS + 6);
    chk(!dev_req, "R8 req held low while device ack high", dev_req, 0);
    dev_ack = 1'b0;
    wait_out(0, 1'b1, n);
    chk(n == SS + 2, "R8 req rise after device ack drop", n, SS + 2);
    dev_ack = 1'b1;
    wait_out(2, 1'b1, n);
    rd_strobe = 1'b0;
    wait_out(0, 1'b0, n);
    dev_ack = 1'b0;
    idle(SS + 3);
    chk(!proto_err && !dev_req, "R10 early strobe is legal", proto_err, 0);
  endtask

  task automatic t_err_strobe_drop;
    int n;
    rd_strobe = 1'b1;
    wait_out(0, 1'b1, n);
    rd_strobe = 1'b0;
    wait_out(3, 1'b1, n);
    chk(n == SS + 1, "R9 strobe dropped before bus ack", n, SS + 1);
    idle(6);
    chk(proto_err, "R10 error sticky", proto_err, 1);
  endtask

  task automatic t_err_ack_rise;
    int n;
    dev_ack = 1'b1;
    wait_out(3, 1'b1, n);
    chk(n == SS + 1, "R9 device ack without request", n, SS + 1);
  endtask

  task automatic t_err_ack_fall;
    int n;
    rd_strobe = 1'b1;
    wait_out(0, 1'b1, n);
    dev_ack = 1'b1;
    wait_out(1, 1'b1, n);
    chk(!proto_err, "R10 no error mid-read", proto_err, 0);
    dev_ack = 1'b0;
    wait_out(3, 1'b1, n);
    chk(n == SS + 1, "R9 device ack dropped while selected", n, SS + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_read(0, 1'b0);
    for (int i = 0; i < 4; i++) t_read(int'($urandom_range(0, 6)), 1'b0);
    t_early_strobe();
    t_err_strobe_drop();
    t_reset();
    chk(!proto_err, "R10 reset clears error", proto_err, 0);
    t_err_ack_rise();
    t_reset();
    t_err_ack_fall();
    t_reset();
    chk(multi == 0, "R6 single output change per edge", multi, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule